// File: doc/BRIEF.md
# Line-Synchronous One-Bit Pixel Capture and Word Packer

This block pulls a monochrome picture off a serial video wire, one bit per pixel, and hands it downstream as 32-bit words. Every falling edge of the horizontal sync input starts a new scan line. The sync input is asynchronous, so it first passes through a two-flop synchronizer inside the block. After that edge, the block discards a programmable number of sample-enable strobes to step over the blanking region. It then takes exactly 512 pixels from the active area of the line. Pixels are shifted into a word, first pixel in the most significant bit. Each full word is offered downstream for a single cycle.

The sampling clock comes from outside and is marked by the `sample_en` strobe. The block counts only cycles in which that strobe is high. An optional double-rate mode expects two strobes per pixel period and keeps one strobe of each pair, chosen by a phase input. Software can change that phase bit line by line to pull the sampling point towards the middle of the pixel. Downstream has no way to stall the block. If a word is not accepted in the cycle it is offered, that word is lost and a sticky overflow flag records the loss.

Top module: `line_packer`

## Requirements
- R1: A high-to-low transition on `hsync_in` starts a new line. The transition passes through two synchronizer flops and one edge-detect flop, so sample strobes up to three clocks after the transition may be missed. Strobes that come later are processed for the new line.
- R2: After a line starts, the first `skip_count` strobes are discarded. The strobe after them is the first pixel. A `skip_count` of 0 makes the first strobe the first pixel.
- R3: Each line captures exactly 512 pixels into 16 words of 32 bits. The pixel taken first goes into bit 31 of the first word, and the pixel taken last goes into bit 0 of the 16th word.
- R4: The block takes a pixel only in cycles where `sample_en` is high. Gaps of any length between strobes do not change the captured data.
- R5: With `oversample_2x` = 1, capture strobes are numbered 0, 1, 2, ... from the first one after the skip. Only strobes whose number has its low bit equal to `keep_phase` are taken as pixels. The other strobes are ignored.
- R6: Every completed word appears on `word_out` with `word_valid` high for exactly one cycle. The word is accepted if `word_ready` is high in that cycle.
- R7: If `word_valid` is high while `word_ready` is low, that word is dropped and `overflow` goes high. `overflow` then stays high until reset. Capture of the line and of later lines continues normally.
- R8: A new line start during an unfinished capture abandons that capture. Any partly filled word is discarded, and the new line is captured in full.
- R9: `line_done` is high for exactly one cycle: the cycle right after the cycle in which the 16th word of a line was offered. This happens whether or not that word was accepted.
- R10: After a line completes, the block ignores further strobes and emits no words until the next line start.
- R11: While reset is applied and directly after it, `word_valid`, `line_done` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Asynchronous horizontal sync; a falling edge starts a line |
| video_in | input | 1 | Serial pixel bit |
| sample_en | input | 1 | One-cycle strobe marking a sample point |
| skip_count | input | 12 | Strobes discarded after line start |
| oversample_2x | input | 1 | Two strobes per pixel when high |
| keep_phase | input | 1 | Which strobe of each pair is kept in double-rate mode |
| word_out | output | 32 | Packed pixels, first pixel in the MSB |
| word_valid | output | 1 | One-cycle word offer |
| word_ready | input | 1 | Downstream accepts the offered word |
| line_done | output | 1 | One-cycle pulse after the 16th word |
| overflow | output | 1 | Sticky: a word was offered while not ready |

## Verification
The bench runs lines with different skip offsets and strobe gaps. An off-by-one in the skip counter would shift every word by one bit, and bit-order mistakes would reverse the words. In double-rate mode, the bench drives the rejected strobe of each pair with the inverted pixel. A design that keeps the wrong phase therefore returns the complement of the expected data. The bench also aborts a line after 100 pixels: a design that flushed its partial word would emit a fourth word. After a completed line, extra strobes check that the block stays idle. A line run with ready held low checks three things: the overflow flag, the dropped words, and the `line_done` pulse that must still arrive one cycle after the last word offer.

// File: rtl/line_packer.sv
module line_packer #(
  parameter int WORD_W   = 32,
  parameter int LINE_PIX = 512,
  parameter int SKIP_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              video_in,
  input  logic              sample_en,
  input  logic [SKIP_W-1:0] skip_count,
  input  logic              oversample_2x,
  input  logic              keep_phase,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  input  logic              word_ready,
  output logic              line_done,
  output logic              overflow
);
  localparam int PIX_W = $clog2(LINE_PIX);
  localparam int SUB_W = $clog2(WORD_W);

  typedef enum logic [1:0] {ST_IDLE, ST_SKIP, ST_CAP} st_t;

  st_t               state;
  logic [2:0]        hs_q;
  logic [SKIP_W-1:0] skip_left;
  logic [PIX_W-1:0]  pix_cnt;
  logic              half;
  logic              done_q;
  logic [WORD_W-1:0] shreg;

  wire line_start = hs_q[2] & ~hs_q[1];
  wire cap_hit    = (state == ST_CAP) && sample_en && !line_start;
  wire take       = cap_hit && (!oversample_2x || (half == keep_phase));
  wire word_full  = take && (pix_cnt[SUB_W-1:0] == '1);
  wire line_end   = take && (pix_cnt == PIX_W'(LINE_PIX - 1));
  wire [WORD_W-1:0] next_shift = {shreg[WORD_W-2:0], video_in};

  always_ff @(posedge clk) begin
    if (!rst_n) hs_q <= 3'b111;
    else        hs_q <= {hs_q[1:0], hsync_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      skip_left <= '0;
      pix_cnt   <= '0;
      half      <= 1'b0;
      shreg     <= '0;
    end else if (line_start) begin
      state     <= (skip_count == '0) ? ST_CAP : ST_SKIP;
      skip_left <= skip_count;
      pix_cnt   <= '0;
      half      <= 1'b0;
      shreg     <= '0;
    end else begin
      case (state)
        ST_SKIP: if (sample_en) begin
          skip_left <= skip_left - 1'b1;
          if (skip_left == SKIP_W'(1)) state <= ST_CAP;
        end
        ST_CAP: if (sample_en) begin
          if (oversample_2x) half <= ~half;
          if (take) begin
            shreg   <= next_shift;
            pix_cnt <= pix_cnt + 1'b1;
            if (line_end) state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_valid <= 1'b0;
      done_q     <= 1'b0;
      line_done  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      word_valid <= word_full;
      if (word_full) word_out <= next_shift;
      done_q    <= line_end;
      line_done <= done_q;
      overflow  <= overflow | (word_valid & ~word_ready);
    end
  end

  assert_word_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  assert_done_after_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> $past(word_valid));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);
  assert_overflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(word_valid && !word_ready));
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_abort_no_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !word_valid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !line_start) |=> !word_valid);
endmodule

// File: tb/line_packer_tb.sv
module line_packer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsync_in = 1'b1;
  logic        video_in = 1'b0;
  logic        sample_en = 1'b0;
  logic [11:0] skip_count = '0;
  logic        oversample_2x = 1'b0;
  logic        keep_phase = 1'b0;
  logic [31:0] word_out;
  logic        word_valid;
  logic        word_ready = 1'b1;
  logic        line_done;
  logic        overflow;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] got [0:63];
  int ngot = 0, ndone = 0, nvalid = 0, dbl_valid = 0;
  int cyc = 0, last_valid_cyc = -10, done_gap_bad = 0;
  logic prev_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_packer u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .video_in(video_in),
    .sample_en(sample_en), .skip_count(skip_count), .oversample_2x(oversample_2x),
    .keep_phase(keep_phase), .word_out(word_out), .word_valid(word_valid),
    .word_ready(word_ready), .line_done(line_done), .overflow(overflow)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (word_valid) begin
        nvalid <= nvalid + 1;
        last_valid_cyc <= cyc;
        if (word_ready && ngot < 64) begin
          got[ngot] <= word_out;
          ngot <= ngot + 1;
        end
      end
      if (word_valid && prev_valid) dbl_valid <= dbl_valid + 1;
      prev_valid <= word_valid;
      if (line_done) begin
        ndone <= ndone + 1;
        if (cyc != last_valid_cyc + 1) done_gap_bad <= done_gap_bad + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit pat(input int seed, input int i);
    int v;
    v = i * 13 + seed * 7;
    return v[2] ^ v[5] ^ i[0];
  endfunction

  function automatic logic [31:0] exp_word(input int seed, input int w);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[31-b] = pat(seed, w * 32 + b);
    return r;
  endfunction

  task automatic clear_counts();
    @(negedge clk);
    ngot = 0; ndone = 0; nvalid = 0; dbl_valid = 0; done_gap_bad = 0;
  endtask

  task automatic start_line();
    @(negedge clk);
    hsync_in = 1'b0;
    repeat (4) @(negedge clk);
    hsync_in = 1'b1;
  endtask

  task automatic strobes(input int seed, input int skip, input bit ovs, input bit ph,
                         input int gap, input int limit);
    int total;
    total = skip + (ovs ? 1024 : 512);
    if (limit >= 0 && limit < total) total = limit;
    for (int j = 0; j < total; j++) begin
      int k;
      k = j - skip;
      if (j < skip) video_in = j[0];
      else if (ovs) video_in = (k[0] == ph) ? pat(seed, k >>> 1) : ~pat(seed, k >>> 1);
      else video_in = pat(seed, k);
      sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
      repeat (gap) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic run_line(input int seed, input int skip, input bit ovs, input bit ph,
                          input int gap, input int limit);
    skip_count = 12'(skip);
    oversample_2x = ovs;
    keep_phase = ph;
    start_line();
    strobes(seed, skip, ovs, ph, gap, limit);
  endtask

  task automatic check_words(input int seed, input int base, input int n, input string req);
    int bad;
    bad = 0;
    for (int w = 0; w < n; w++) begin
      if (got[base + w] !== exp_word(seed, w)) begin
        bad++;
        $display("FAIL %s: word %0d actual %h expected %h", req, w, got[base + w], exp_word(seed, w));
      end
    end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  task automatic t_reset();
    chk(word_valid === 1'b0, "R11 word_valid", int'(word_valid), 0);
    chk(line_done === 1'b0, "R11 line_done", int'(line_done), 0);
    chk(overflow === 1'b0, "R11 overflow", int'(overflow), 0);
  endtask

  task automatic t_basic();
    clear_counts();
    run_line(1, 0, 0, 0, 0, -1);
    chk(ngot == 16, "R3 word count", ngot, 16);
    check_words(1, 0, 16, "R3/R1 data");
    chk(ndone == 1, "R9 done count", ndone, 1);
    chk(done_gap_bad == 0, "R9 done timing", done_gap_bad, 0);
    chk(dbl_valid == 0, "R6 single-cycle valid", dbl_valid, 0);
  endtask

  task automatic t_offsets();
    clear_counts();
    run_line(2, 5, 0, 0, 1, -1);
    chk(ngot == 16, "R2 count skip5", ngot, 16);
    check_words(2, 0, 16, "R2/R4 skip5 gap1");
    clear_counts();
    run_line(3, 37, 0, 0, 2, -1);
    chk(ngot == 16, "R2 count skip37", ngot, 16);
    check_words(3, 0, 16, "R2/R4 skip37 gap2");
  endtask

  task automatic t_oversample();
    clear_counts();
    run_line(4, 3, 1, 0, 0, -1);
    chk(ngot == 16, "R5 count phase0", ngot, 16);
    check_words(4, 0, 16, "R5 phase0");
    clear_counts();
    run_line(5, 10, 1, 1, 1, -1);
    chk(ngot == 16, "R5 count phase1", ngot, 16);
    check_words(5, 0, 16, "R5 phase1");
    chk(ndone == 1, "R9 done 2x", ndone, 1);
  endtask

  task automatic t_abort();
    clear_counts();
    run_line(6, 0, 0, 0, 0, 100);
    chk(ngot == 3, "R8 partial words", ngot, 3);
    run_line(7, 4, 0, 0, 1, -1);
    chk(ngot == 19, "R8 total words", ngot, 19);
    check_words(6, 0, 3, "R8 aborted line data");
    check_words(7, 3, 16, "R8 new line data");
    chk(ndone == 1, "R8 done once", ndone, 1);
  endtask

  task automatic t_idle();
    clear_counts();
    run_line(8, 2, 0, 0, 0, -1);
    chk(ngot == 16, "R10 line words", ngot, 16);
    for (int j = 0; j < 200; j++) begin
      video_in = j[1];
      sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
    end
    repeat (5) @(negedge clk);
    chk(nvalid == 16, "R10 no words in idle", nvalid, 16);
    chk(ndone == 1, "R10 no extra done", ndone, 1);
  endtask

  task automatic t_overflow();
    chk(overflow === 1'b0, "R7 overflow clear before", int'(overflow), 0);
    clear_counts();
    word_ready = 1'b0;
    run_line(9, 6, 0, 0, 0, -1);
    chk(ngot == 0, "R7 words dropped", ngot, 0);
    chk(nvalid == 16, "R7 offers made", nvalid, 16);
    chk(overflow === 1'b1, "R7 overflow set", int'(overflow), 1);
    chk(ndone == 1, "R9 done without accept", ndone, 1);
    chk(done_gap_bad == 0, "R9 done timing no accept", done_gap_bad, 0);
    word_ready = 1'b1;
    clear_counts();
    run_line(10, 1, 0, 0, 1, -1);
    chk(ngot == 16, "R7 capture continues", ngot, 16);
    check_words(10, 0, 16, "R7 data after overflow");
    chk(overflow === 1'b1, "R7 overflow sticky", int'(overflow), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_offsets();
    t_oversample();
    t_abort();
    t_idle();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule